// File: doc/BRIEF.md
# Frame-Synchronous Handshake Byte Channel

This block carries a byte-wide message stream over a time-division serial frame that repeats at 8 kHz. Every frame holds one data byte and two handshake bits: a transmit-valid bit (here called the send flag) and a receive-acknowledge bit (the ack flag). Both bits are active low and rest at 1. Transfers line up with the frame strobe, but the message pace is set only by the handshake. A byte is repeated in every frame until the peer acknowledges it, so a byte can take any number of frames to deliver.

The block has a transmit side and a receive side. A processor control bit gates each side. While a control bit is 0, its outgoing handshake bit is forced to the idle level and that side stays idle. While the bit is 1, the protocol logic drives it. The processor sees sticky status flags through a small register port: byte received, end of message, byte acknowledged, transfer aborted, and transmission active. A read clears the first four. Bit-level serialisation is outside the block. It exchanges whole frame slots, one per frame strobe. Two copies can sit side by side, one per channel, each with its own controls and flags.

Top module: `frame_hs_channel`

## Requirements
- R1: Input slots are sampled, and the send flag, ack flag and data output slots change, only on a clock edge where `frameStrobe` is 1. A byte written between strobes leaves `slotMxOut` at 1 until the next strobe. The one exception is the immediate forcing in R3.
- R2: A byte accepted from idle appears on `slotDataOut` with `slotMxOut`=0 after the next strobe and repeats every frame. The ack flag input is ignored at the first strobe after the byte goes out. At any later strobe, a 0 on `slotMrIn` sets the acknowledged flag, and the send flag then stays 0 (held) until the next command.
- R3: Control register bit 0 is the transmit enable and bit 1 is the receive enable. While the transmit enable is 0, `slotMxOut` is 1 from the clock after the write, and the transmitter returns to idle with any pending byte dropped. While the receive enable is 0, `slotMrOut` is 1 and no byte is taken.
- R4: With the receive enable set, the receiver takes `slotDataIn` when `slotMxIn` was 1 at one strobe and 0 at the next. Taking a byte sets the received flag and drives `slotMrOut`=0 from that strobe on. A send flag that stays low takes nothing further.
- R5: While the receiver is acknowledging, `slotMxIn`=1 at two consecutive strobes sets the end-of-message flag, and `slotMrOut` returns to 1 at the second of those strobes.
- R6: While sending, `slotMrIn`=1 at two consecutive strobes (the ignored first strobe not counted) sets the abort flag, clears the active flag and returns `slotMxOut` to 1.
- R7: A byte written in the held state gives one frame with `slotMxOut`=1, then the new byte with `slotMxOut`=0. A byte written while a byte is still being sent is ignored, and the byte on the slot does not change.
- R8: Writing 1 to bit 0 at address 2 in the held state ends the message: after the next strobe `slotMxOut` is 1 and the active flag is clear.
- R9: The active flag is set when a byte is accepted from idle. It is cleared by an end of message, an abort or a transmit disable.
- R10: Address 0 reads and writes the control bits {rx enable, tx enable} in bits [1:0]. A write to address 1 offers a byte for sending, and a read of address 1 returns the last byte received. A read of address 2 returns the status: bit 0 received, bit 1 end of message, bit 2 acknowledged, bit 3 abort, bit 4 active. Read data appears on `regRdData` in the cycle after `regRdEn`.
- R11: Status bits 0 to 3 are sticky, and a read of address 2 clears them. A flag set in the same cycle as that read stays set. The active bit is not cleared by a read.
- R12: After reset, `slotMxOut` and `slotMrOut` are 1, `slotDataOut` is 0, both enables are 0, all status bits are 0 and `regRdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| frameStrobe | input | 1 | One-cycle pulse at each frame boundary |
| slotMxIn | input | 1 | Peer's send flag for the frame just ended (active low) |
| slotMrIn | input | 1 | Peer's ack flag for the frame just ended (active low) |
| slotDataIn | input | 8 | Peer's data byte for the frame just ended |
| slotMxOut | output | 1 | Send flag for the coming frame (active low) |
| slotMrOut | output | 1 | Ack flag for the coming frame (active low) |
| slotDataOut | output | 8 | Data byte for the coming frame |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, valid the cycle after a read |

## Verification
The bench covers the first strobe after a byte goes out. A transmitter that believed the stale ack flag there would report an acknowledgement the receiver never gave. It also covers a single frame of high ack flag between a low one and an acknowledgement, which a miscounting transmitter would take as an abort. A write made while a byte is still in flight would corrupt the slot if not ignored, and a status read that lands in the same cycle as a byte take would lose the received flag if the clear beat the set. A long random stream of send-flag levels drives the receiver. A receiver that took a byte on a level instead of a falling edge, or closed the message after one idle frame, would give the wrong ack flag or the wrong flags in some frame.

// File: rtl/fhc_pkg.sv
package fhc_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SEND,
    TX_HOLD,
    TX_GAP
  } txState_t;

  typedef enum logic {
    RX_IDLE,
    RX_ACK
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic holdLoad;   // latch offered byte into hold register
    logic slotLoad;   // copy hold register onto the data slot
    logic rxTake;     // capture incoming data slot
    logic setRecv;
    logic setEnd;
    logic setAck;
    logic setAbort;
  } fhcStrobe_t;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_DATA = 1;
  localparam int ADDR_STAT = 2;

  localparam int ST_RECV   = 0;
  localparam int ST_END    = 1;
  localparam int ST_ACK    = 2;
  localparam int ST_ABORT  = 3;
  localparam int ST_ACTIVE = 4;

endpackage

// File: rtl/fhc_ctrl.sv
module fhc_ctrl
  import fhc_pkg::*;
#(
  parameter int ABORT_FRAMES = 2,
  parameter int EOM_FRAMES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frameStrobe,
  input  logic       mxIn,
  input  logic       mrIn,
  input  logic       txEn,
  input  logic       rxEn,
  input  logic       wrSend,
  input  logic       wrEnd,
  output logic       mxOut,
  output logic       mrOut,
  output logic       txActive,
  output fhcStrobe_t stb
);

  localparam int ACW = $clog2(ABORT_FRAMES + 1);
  localparam int ECW = $clog2(EOM_FRAMES + 1);
  localparam logic [ACW-1:0] ABORT_LAST = ACW'(ABORT_FRAMES - 1);
  localparam logic [ECW-1:0] EOM_LAST   = ECW'(EOM_FRAMES - 1);

  txState_t       txState;
  rxState_t       rxState;
  logic           sendPend;
  logic           endPend;
  logic           skipFirst;
  logic [ACW-1:0] mrHighCnt;
  logic [ECW-1:0] mxHighCnt;
  logic           mxReg;
  logic           mrReg;
  logic           prevMx;
  logic           activeReg;

  logic canAccept;
  logic endAccept;
  logic sendCheck;
  logic mxFall;

  // ---------------- transmit decisions ----------------
  assign canAccept = txEn && !sendPend &&
                     (txState == TX_IDLE || txState == TX_HOLD);
  assign endAccept = txEn && !sendPend && (txState == TX_HOLD);
  assign sendCheck = frameStrobe && txEn && (txState == TX_SEND) && !skipFirst;

  // ---------------- receive decisions ----------------
  assign mxFall = prevMx && !mxIn;

  always_comb begin
    stb          = '0;
    stb.holdLoad = wrSend && canAccept;
    stb.slotLoad = frameStrobe && txEn &&
                   ((txState == TX_IDLE && sendPend) || txState == TX_GAP);
    stb.setAck   = sendCheck && !mrIn;
    stb.setAbort = sendCheck && mrIn && (mrHighCnt == ABORT_LAST);
    stb.rxTake   = frameStrobe && rxEn && mxFall;
    stb.setRecv  = stb.rxTake;
    stb.setEnd   = frameStrobe && rxEn && (rxState == RX_ACK) && mxIn &&
                   (mxHighCnt == EOM_LAST);
  end

  // ---------------- transmit state machine ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      txState   <= TX_IDLE;
      sendPend  <= 1'b0;
      endPend   <= 1'b0;
      skipFirst <= 1'b0;
      mrHighCnt <= '0;
      mxReg     <= 1'b1;
      activeReg <= 1'b0;
    end else if (!txEn) begin
      txState   <= TX_IDLE;
      sendPend  <= 1'b0;
      endPend   <= 1'b0;
      skipFirst <= 1'b0;
      mrHighCnt <= '0;
      mxReg     <= 1'b1;
      activeReg <= 1'b0;
    end else begin
      if (stb.holdLoad) begin
        sendPend <= 1'b1;
        if (txState == TX_IDLE) activeReg <= 1'b1;
      end
      if (wrEnd && endAccept) endPend <= 1'b1;
      if (frameStrobe) begin
        unique case (txState)
          TX_IDLE: begin
            if (sendPend) begin
              txState   <= TX_SEND;
              sendPend  <= 1'b0;
              mxReg     <= 1'b0;
              skipFirst <= 1'b1;
              mrHighCnt <= '0;
            end
          end
          TX_SEND: begin
            if (skipFirst) begin
              skipFirst <= 1'b0;
            end else if (stb.setAck) begin
              txState   <= TX_HOLD;
              mrHighCnt <= '0;
            end else if (stb.setAbort) begin
              txState   <= TX_IDLE;
              mxReg     <= 1'b1;
              activeReg <= 1'b0;
              mrHighCnt <= '0;
            end else begin
              mrHighCnt <= mrHighCnt + 1'b1;
            end
          end
          TX_HOLD: begin
            if (sendPend) begin
              txState  <= TX_GAP;
              sendPend <= 1'b0;
              mxReg    <= 1'b1;
            end else if (endPend) begin
              txState   <= TX_IDLE;
              endPend   <= 1'b0;
              mxReg     <= 1'b1;
              activeReg <= 1'b0;
            end
          end
          TX_GAP: begin
            txState   <= TX_SEND;
            mxReg     <= 1'b0;
            skipFirst <= 1'b1;
            mrHighCnt <= '0;
          end
          default: txState <= TX_IDLE;
        endcase
      end
    end
  end

  // ---------------- receive state machine ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      prevMx <= 1'b1;
    end else if (frameStrobe) begin
      prevMx <= mxIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rxEn) begin
      rxState   <= RX_IDLE;
      mxHighCnt <= '0;
      mrReg     <= 1'b1;
    end else if (frameStrobe) begin
      if (stb.rxTake) begin
        rxState   <= RX_ACK;
        mrReg     <= 1'b0;
        mxHighCnt <= '0;
      end else if (rxState == RX_ACK) begin
        if (stb.setEnd) begin
          rxState   <= RX_IDLE;
          mrReg     <= 1'b1;
          mxHighCnt <= '0;
        end else if (mxIn) begin
          mxHighCnt <= mxHighCnt + 1'b1;
        end else begin
          mxHighCnt <= '0;
        end
      end
    end
  end

  assign mxOut    = mxReg | ~txEn;
  assign mrOut    = mrReg | ~rxEn;
  assign txActive = activeReg;

endmodule

// File: rtl/fhc_datapath.sv
module fhc_datapath
  import fhc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] slotDataIn,
  input  fhcStrobe_t        stb,
  input  logic              txActive,
  output logic [DATA_W-1:0] slotDataOut,
  output logic              txEn,
  output logic              rxEn,
  output logic              wrSend,
  output logic              wrEnd,
  output logic [DATA_W-1:0] regRdData
);

  localparam int FLAG_N = 4;

  logic [DATA_W-1:0] holdByte;
  logic [DATA_W-1:0] slotByte;
  logic [DATA_W-1:0] rxByte;
  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] flagSet;
  logic [DATA_W-1:0] rdNext;
  logic              readClear;
  logic              ctrlWr;

  assign ctrlWr    = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
  assign wrSend    = regWrEn && (regAddr == ADDR_W'(ADDR_DATA));
  assign wrEnd     = regWrEn && (regAddr == ADDR_W'(ADDR_STAT)) && regWrData[0];
  assign readClear = regRdEn && (regAddr == ADDR_W'(ADDR_STAT));

  assign flagSet[ST_RECV]  = stb.setRecv;
  assign flagSet[ST_END]   = stb.setEnd;
  assign flagSet[ST_ACK]   = stb.setAck;
  assign flagSet[ST_ABORT] = stb.setAbort;

  always_ff @(posedge clk) begin
    if (rst) begin
      txEn <= 1'b0;
      rxEn <= 1'b0;
    end else if (ctrlWr) begin
      txEn <= regWrData[0];
      rxEn <= regWrData[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdByte <= '0;
      slotByte <= '0;
      rxByte   <= '0;
    end else begin
      if (stb.holdLoad) holdByte <= regWrData;
      if (stb.slotLoad) slotByte <= holdByte;
      if (stb.rxTake)   rxByte   <= slotDataIn;
    end
  end

  // sticky flags: a set in the same cycle as a clearing read wins
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= flagSet[i] | (flags[i] & ~readClear);
    end
  end

  always_comb begin
    rdNext = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) begin
      rdNext[0] = txEn;
      rdNext[1] = rxEn;
    end else if (regAddr == ADDR_W'(ADDR_DATA)) begin
      rdNext = rxByte;
    end else if (regAddr == ADDR_W'(ADDR_STAT)) begin
      rdNext[FLAG_N-1:0] = flags;
      rdNext[ST_ACTIVE]  = txActive;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          regRdData <= '0;
    else if (regRdEn) regRdData <= rdNext;
  end

  assign slotDataOut = slotByte;

endmodule

// File: rtl/frame_hs_channel.sv
module frame_hs_channel
  import fhc_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 2,
  parameter int ABORT_FRAMES = 2,
  parameter int EOM_FRAMES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frameStrobe,
  input  logic              slotMxIn,
  input  logic              slotMrIn,
  input  logic [DATA_W-1:0] slotDataIn,
  output logic              slotMxOut,
  output logic              slotMrOut,
  output logic [DATA_W-1:0] slotDataOut,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);

  fhcStrobe_t stb;
  logic       txEn;
  logic       rxEn;
  logic       wrSend;
  logic       wrEnd;
  logic       txActive;

  fhc_ctrl #(
    .ABORT_FRAMES(ABORT_FRAMES),
    .EOM_FRAMES  (EOM_FRAMES)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frameStrobe(frameStrobe),
    .mxIn       (slotMxIn),
    .mrIn       (slotMrIn),
    .txEn       (txEn),
    .rxEn       (rxEn),
    .wrSend     (wrSend),
    .wrEnd      (wrEnd),
    .mxOut      (slotMxOut),
    .mrOut      (slotMrOut),
    .txActive   (txActive),
    .stb        (stb)
  );

  fhc_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .slotDataIn (slotDataIn),
    .stb        (stb),
    .txActive   (txActive),
    .slotDataOut(slotDataOut),
    .txEn       (txEn),
    .rxEn       (rxEn),
    .wrSend     (wrSend),
    .wrEnd      (wrEnd),
    .regRdData  (regRdData)
  );

endmodule

// File: rtl/fhc_checker.sv
module fhc_checker (
  input logic clk,
  input logic rst,
  input logic frameStrobe,
  input logic slotMxOut,
  input logic slotMrOut,
  input logic txEn,
  input logic rxEn,
  input logic txActive,
  input logic setAck,
  input logic setAbort,
  input logic rxTake
);

  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  // R1: send flag moves only after a frame strobe while enabled
  a_r1_mx_moves_on_frame: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(frameStrobe) && $past(txEn) && txEn) |-> $stable(slotMxOut));

  // R3: disabled sides show the idle level
  a_r3_mx_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !txEn |-> slotMxOut);
  a_r3_mr_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !rxEn |-> slotMrOut);

  // R2: an acknowledged byte keeps the send flag low
  a_r2_ack_holds_mx: assert property (@(posedge clk) disable iff (rst)
    setAck |=> !slotMxOut);

  // R4: a taken byte is acknowledged on the next frame
  a_r4_take_drives_mr: assert property (@(posedge clk) disable iff (rst)
    rxTake |=> !slotMrOut);

  // R6: abort drops the active flag and releases the send flag
  a_r6_abort_drops_active: assert property (@(posedge clk) disable iff (rst)
    setAbort |=> (!txActive && slotMxOut));

  // R6: ack and abort never coincide
  a_r6_ack_abort_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({setAck, setAbort}));

endmodule

bind frame_hs_channel fhc_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .frameStrobe(frameStrobe),
  .slotMxOut  (slotMxOut),
  .slotMrOut  (slotMrOut),
  .txEn       (txEn),
  .rxEn       (rxEn),
  .txActive   (txActive),
  .setAck     (stb.setAck),
  .setAbort   (stb.setAbort),
  .rxTake     (stb.rxTake)
);

// File: tb/frame_hs_channel_test.sv
module frame_hs_channel_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       frameStrobe;
  logic       slotMxIn, slotMrIn;
  logic [7:0] slotDataIn;
  logic       slotMxOut, slotMrOut;
  logic [7:0] slotDataOut;
  logic       regWrEn, regRdEn;
  logic [1:0] regAddr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  frame_hs_channel uut (
    .clk(clk), .rst(rst), .frameStrobe(frameStrobe),
    .slotMxIn(slotMxIn), .slotMrIn(slotMrIn), .slotDataIn(slotDataIn),
    .slotMxOut(slotMxOut), .slotMrOut(slotMrOut), .slotDataOut(slotDataOut),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] statusExp(input bit recv, input bit eom,
                                           input bit ack, input bit abrt, input bit act);
    return {3'b000, act, abrt, ack, eom, recv};
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    v = regRdData;
  endtask

  task automatic frame(input logic mx, input logic mr, input logic [7:0] d);
    @(negedge clk);
    slotMxIn = mx; slotMrIn = mr; slotDataIn = d; frameStrobe = 1'b1;
    @(negedge clk);
    frameStrobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish;
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish();
  end

  initial begin
    logic [7:0] v;
    bit mAck, mPrev;
    int mHi;
    void'($urandom(32'h5eed_c0de));
    rst = 1'b1; frameStrobe = 1'b0; slotMxIn = 1'b1; slotMrIn = 1'b1;
    slotDataIn = '0; regWrEn = 1'b0; regRdEn = 1'b0; regAddr = '0; regWrData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R12 mx after reset", slotMxOut, 1);
    check("R12 mr after reset", slotMrOut, 1);
    check("R12 data after reset", slotDataOut, 0);
    check("R12 rdData after reset", regRdData, 0);
    regRead(2, v); check("R12 status after reset", v, 0);
    regRead(0, v); check("R12 ctrl after reset", v, 0);

    // transmit path, receiver off
    regWrite(0, 8'h01);
    regRead(0, v); check("R10 ctrl readback", v, 8'h01);
    regWrite(1, 8'hA5);
    check("R1 no change before strobe", slotMxOut, 1);
    regRead(2, v); check("R9 active on accept", v, statusExp(0,0,0,0,1));
    frame(1, 1, 0);
    check("R2 mx low after accept", slotMxOut, 0);
    check("R2 byte on slot", slotDataOut, 8'hA5);
    regWrite(1, 8'h3C);
    frame(1, 0, 0);
    check("R2 stale ack ignored", slotMxOut, 0);
    check("R7 write during send ignored", slotDataOut, 8'hA5);
    regRead(2, v); check("R2 no ack on first strobe", v, statusExp(0,0,0,0,1));
    frame(1, 1, 0);
    check("R6 single high frame no abort", slotMxOut, 0);
    frame(1, 0, 0);
    regRead(2, v); check("R2 ack flag set", v, statusExp(0,0,1,0,1));
    check("R2 mx held low after ack", slotMxOut, 0);
    frame(1, 1, 0);
    check("R2 held state keeps mx low", slotMxOut, 0);

    // next byte in held state
    regWrite(1, 8'h5A);
    frame(1, 0, 0);
    check("R7 gap frame mx high", slotMxOut, 1);
    frame(1, 0, 0);
    check("R7 new byte mx low", slotMxOut, 0);
    check("R7 new byte on slot", slotDataOut, 8'h5A);
    frame(1, 0, 0);
    frame(1, 0, 0);
    regRead(2, v); check("R2 second ack", v, statusExp(0,0,1,0,1));

    // end of message
    regWrite(2, 8'h01);
    frame(1, 0, 0);
    check("R8 end releases mx", slotMxOut, 1);
    regRead(2, v); check("R8 active cleared by end", v, statusExp(0,0,0,0,0));

    // abort
    regWrite(1, 8'h11);
    frame(1, 1, 0);
    frame(1, 1, 0);
    frame(1, 1, 0);
    check("R6 mx low before abort", slotMxOut, 0);
    frame(1, 1, 0);
    check("R6 abort releases mx", slotMxOut, 1);
    regRead(2, v); check("R6 abort flag and R9 active clear", v, statusExp(0,0,0,1,0));
    regRead(2, v); check("R11 read clears abort", v, 0);

    // transmit disable mid send
    regWrite(1, 8'h22);
    frame(1, 1, 0);
    check("R2 sending before disable", slotMxOut, 0);
    regWrite(0, 8'h00);
    check("R3 disable forces mx high", slotMxOut, 1);
    regRead(2, v); check("R9 disable clears active", v, 0);
    regWrite(0, 8'h01);
    frame(1, 1, 0);
    check("R3 pending byte dropped", slotMxOut, 1);

    // receiver disabled ignores a falling send flag
    frame(1, 1, 8'h00);
    frame(0, 1, 8'h99);
    check("R3 rx off mr idle", slotMrOut, 1);
    regRead(2, v); check("R3 rx off no take", v, 0);

    // receiver on, transmitter off
    regWrite(0, 8'h02);
    frame(1, 1, 0);
    regRead(2, v);
    // take and clearing read in the same cycle
    @(negedge clk);
    slotMxIn = 1'b0; slotDataIn = 8'h77; frameStrobe = 1'b1;
    regRdEn = 1'b1; regAddr = 2'd2;
    @(negedge clk);
    frameStrobe = 1'b0; regRdEn = 1'b0;
    check("R11 read shows old status", regRdData, 0);
    check("R4 mr low after take", slotMrOut, 0);
    regRead(2, v); check("R11 set wins over clear", v, statusExp(1,0,0,0,0));
    regRead(1, v); check("R4 received byte", v, 8'h77);
    frame(0, 1, 8'h66);
    regRead(2, v); check("R4 steady low takes nothing", v, 0);
    frame(1, 1, 0);
    check("R5 one idle frame keeps ack", slotMrOut, 0);
    regRead(2, v); check("R5 no end after one frame", v, 0);
    frame(1, 1, 0);
    check("R5 end releases mr", slotMrOut, 1);
    regRead(2, v); check("R5 end flag", v, statusExp(0,1,0,0,0));

    // random send-flag stream into the receiver
    mAck = 0; mPrev = 1; mHi = 0;
    for (int i = 0; i < 150; i++) begin
      logic mx;
      logic [7:0] d;
      bit took, eom;
      mx = 1'($urandom_range(0, 1));
      d = 8'($urandom);
      took = 0; eom = 0;
      if (mPrev && !mx) begin
        took = 1; mAck = 1; mHi = 0;
      end else if (mAck) begin
        if (mx) begin
          mHi++;
          if (mHi == 2) begin eom = 1; mAck = 0; mHi = 0; end
        end else mHi = 0;
      end
      mPrev = mx;
      frame(mx, 1, d);
      check("R4 R5 random mr", slotMrOut, mAck ? 0 : 1);
      regRead(2, v);
      check("R4 R5 random status", v, statusExp(took, eom, 0, 0, 0));
      if (took) begin
        regRead(1, v);
        check("R4 random byte", v, d);
      end
    end

    finish();
  end

endmodule